// File: doc/BRIEF.md
# Programmable Duty Channel Divider

This block divides its input clock by a ratio set through two independent counts: one for the number of input cycles the output spends high, one for the number it spends low. Each count uses minus-one encoding, so a count of zero gives a single input cycle in that level. A start-level select decides which level the waveform opens with after a realignment. A phase offset delays the opening of the waveform by a set number of input cycles.

Several channels of a clock tree share one chip-level SYNC pulse. While SYNC is asserted and obeyed, each channel holds its start level and clears its counters. On release, each channel waits its own offset and then runs, so channels with the same counts stay in a fixed phase relation. A channel can also ignore SYNC, and in that mode it drives a static level chosen by a force input. It can pass the input clock straight through in bypass mode, or it can be powered down. Leaving power-down restarts the channel exactly as a SYNC release does.

Top module: `cdv_channel`

## Requirements
- R1: In divider mode the output stays low for lo_cnt+1 consecutive input cycles in every low phase.
- R2: In divider mode the output stays high for hi_cnt+1 consecutive input cycles in every high phase.
- R3: With bypass set and the channel powered, clk_out equals clk (high while clk is high, low while clk is low).
- R4: While sync_in is sampled high and ign_sync is 0, the output holds the start level. After the last such edge the waveform restarts from cycle 0, so two channels with equal settings produce identical outputs.
- R5: With ign_sync set (and no bypass or power-down), the output is a static level equal to force_hi (1 = high, 0 = low), and sync_in has no effect on it.
- R6: start_hi=1 makes the waveform open with its high phase after a restart; start_hi=0 makes it open with its low phase.
- R7: After a restart the output holds the start level for phase_ofs extra input cycles before the first phase begins, so the waveform is delayed by exactly phase_ofs cycles.
- R8: While pwr_dn is 1 the output is low, and the divider state does not change.
- R9: The first edge with pwr_dn back at 0 acts as a single sync edge: the waveform restarts as in R4, counted from that edge.
- R10: The synchronous reset rst behaves like an obeyed sync edge: the output takes the start level, and the waveform restarts when rst is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider input clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_in | input | 1 | Chip-level realignment pulse, active high |
| hi_cnt | input | CNT_W | High duration minus one |
| lo_cnt | input | CNT_W | Low duration minus one |
| bypass | input | 1 | 1 passes clk straight to the output |
| ign_sync | input | 1 | 1 ignores sync_in and makes the output static |
| force_hi | input | 1 | Static level used when ign_sync is 1 |
| start_hi | input | 1 | 1 opens the waveform high, 0 opens it low |
| phase_ofs | input | OFS_W | Start delay in input cycles after a restart |
| pwr_dn | input | 1 | 1 stops the channel and drives the output low |
| clk_out | output | 1 | Divided clock |

## Verification
Two channels share clock and SYNC but have different offsets. Randomized high and low counts and start levels run on both, and each output is compared cycle by cycle with a waveform computed from the settings. The random counts separate the high and low widths, because unequal counts show any swap of the two. The differing offsets show that the delay counts from the shared release. Directed cases cover the extreme counts 0 and 15 and a SYNC reasserted mid-waveform. They also cover both force levels, with SYNC pulsed to show that it is ignored, the bypass level on each half of clk, and power-down followed by its restart.

// File: rtl/cdv_pkg.sv
package cdv_pkg;
   // Duration limit of the phase the output is currently in.
   function automatic logic [15:0] phase_limit(input logic level,
                                               input logic [15:0] hi,
                                               input logic [15:0] lo);
      return level ? hi : lo;
   endfunction
endpackage

// File: rtl/cdv_phase_wait.sv
module cdv_phase_wait #(
   parameter int OFS_W = 4
) (
   input  logic             clk,
   input  logic             hold,
   input  logic             freeze,
   input  logic [OFS_W-1:0] ofs,
   output logic             go,
   output logic             running
);
   logic [OFS_W-1:0] wcnt_q;
   logic             reached;

   assign reached = (wcnt_q >= ofs);
   assign go      = running | reached;

   always_ff @(posedge clk) begin
      if (hold) begin
         wcnt_q  <= '0;
         running <= 1'b0;
      end else if (!freeze && !running) begin
         if (reached) running <= 1'b1;
         else         wcnt_q  <= wcnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/cdv_duty_counter.sv
module cdv_duty_counter
   import cdv_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             hold,
   input  logic             freeze,
   input  logic             step,
   input  logic             start_lvl,
   input  logic [CNT_W-1:0] hi,
   input  logic [CNT_W-1:0] lo,
   output logic             level,
   output logic [CNT_W-1:0] cnt_q
);
   logic [15:0]      lim_w;
   logic [CNT_W-1:0] lim;

   assign lim_w = phase_limit(level, 16'(hi), 16'(lo));
   assign lim   = lim_w[CNT_W-1:0];

   always_ff @(posedge clk) begin
      if (hold) begin
         level <= start_lvl;
         cnt_q <= '0;
      end else if (!freeze && step) begin
         if (cnt_q >= lim) begin
            level <= ~level;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/cdv_out_select.sv
module cdv_out_select #(
   parameter bit HAS_BYPASS = 1'b1
) (
   input  logic clk,
   input  logic bypass,
   input  logic ign_sync,
   input  logic force_hi,
   input  logic pwr_dn,
   input  logic div_lvl,
   output logic clk_out
);
   logic core_lvl;
   logic path_lvl;

   assign core_lvl = ign_sync ? force_hi : div_lvl;

   generate
      if (HAS_BYPASS) begin : g_bypass
         assign path_lvl = bypass ? clk : core_lvl;
      end else begin : g_no_bypass
         logic unused_byp;
         assign unused_byp = bypass ^ clk;
         assign path_lvl   = core_lvl;
      end
   endgenerate

   assign clk_out = pwr_dn ? 1'b0 : path_lvl;
endmodule

// File: rtl/cdv_channel.sv
module cdv_channel #(
   parameter int CNT_W      = 4,
   parameter int OFS_W      = 4,
   parameter bit HAS_BYPASS = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sync_in,
   input  logic [CNT_W-1:0] hi_cnt,
   input  logic [CNT_W-1:0] lo_cnt,
   input  logic             bypass,
   input  logic             ign_sync,
   input  logic             force_hi,
   input  logic             start_hi,
   input  logic [OFS_W-1:0] phase_ofs,
   input  logic             pwr_dn,
   output logic             clk_out
);
   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("cdv_channel: CNT_W must lie in 1..16");
      end
      if (OFS_W < 1) begin : g_bad_ofs
         $error("cdv_channel: OFS_W must be at least 1");
      end
   endgenerate

   logic             pd_seen;
   logic             pd_exit;
   logic             hold;
   logic             freeze;
   logic             go;
   logic             running;
   logic             div_q;
   logic [CNT_W-1:0] cnt_q;

   assign pd_exit = pd_seen & ~pwr_dn;
   assign hold    = rst | (~pwr_dn & ((sync_in & ~ign_sync) | pd_exit));
   assign freeze  = pwr_dn & ~rst;

   always_ff @(posedge clk) begin
      if (rst)          pd_seen <= 1'b0;
      else if (pwr_dn)  pd_seen <= 1'b1;
      else if (pd_exit) pd_seen <= 1'b0;
   end

   cdv_phase_wait #(.OFS_W(OFS_W)) u_wait (
      .clk     (clk),
      .hold    (hold),
      .freeze  (freeze),
      .ofs     (phase_ofs),
      .go      (go),
      .running (running)
   );

   cdv_duty_counter #(.CNT_W(CNT_W)) u_duty (
      .clk       (clk),
      .hold      (hold),
      .freeze    (freeze),
      .step      (go),
      .start_lvl (start_hi),
      .hi        (hi_cnt),
      .lo        (lo_cnt),
      .level     (div_q),
      .cnt_q     (cnt_q)
   );

   cdv_out_select #(.HAS_BYPASS(HAS_BYPASS)) u_sel (
      .clk      (clk),
      .bypass   (bypass),
      .ign_sync (ign_sync),
      .force_hi (force_hi),
      .pwr_dn   (pwr_dn),
      .div_lvl  (div_q),
      .clk_out  (clk_out)
   );
endmodule

// File: rtl/cdv_channel_chk.sv
module cdv_channel_chk #(
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst,
   input logic             sync_in,
   input logic             bypass,
   input logic             ign_sync,
   input logic             force_hi,
   input logic             start_hi,
   input logic             pwr_dn,
   input logic             clk_out,
   input logic             div_q,
   input logic             running,
   input logic [CNT_W-1:0] cnt_q
);
   // R8: powered-down channel drives low
   a_r8_pd_low: assert property (@(posedge clk) disable iff (rst)
      pwr_dn |-> !clk_out);

   // R8: divider state frozen through power-down
   a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
      ($past(pwr_dn) && !$past(rst)) |->
         ($stable(div_q) && $stable(cnt_q) && $stable(running)));

   // R5: static level under ignore-sync
   a_r5_static: assert property (@(posedge clk) disable iff (rst)
      (!pwr_dn && !bypass && ign_sync) |-> (clk_out == force_hi));

   // R4: obeyed sync leaves the output at the start level
   a_r4_sync_hold: assert property (@(posedge clk) disable iff (rst)
      ($past(sync_in) && !$past(ign_sync) && !$past(pwr_dn) && !$past(rst)
       && !pwr_dn && !bypass && !ign_sync) |-> (clk_out == $past(start_hi)));

   // R7: an obeyed sync restarts the offset wait
   a_r7_wait_restart: assert property (@(posedge clk) disable iff (rst)
      ($past(sync_in) && !$past(ign_sync) && !$past(pwr_dn)) |-> !running);

   // R10: reset loads the start level
   a_r10_reset_level: assert property (@(posedge clk)
      ($past(rst) && !rst) |-> (div_q == $past(start_hi)));
endmodule

bind cdv_channel cdv_channel_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .sync_in  (sync_in),
   .bypass   (bypass),
   .ign_sync (ign_sync),
   .force_hi (force_hi),
   .start_hi (start_hi),
   .pwr_dn   (pwr_dn),
   .clk_out  (clk_out),
   .div_q    (div_q),
   .running  (running),
   .cnt_q    (cnt_q)
);

// File: tb/cdv_channel_bench.sv
module cdv_channel_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sync_in = 1'b0;
   logic [3:0] hi_cnt = '0, lo_cnt = '0;
   logic       bypass = 1'b0, ign_sync = 1'b0, force_hi = 1'b0, start_hi = 1'b0;
   logic [3:0] ofs_a = '0, ofs_b = '0;
   logic       pwr_dn = 1'b0;
   logic       out_a, out_b;
   int         checks = 0, errors = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   cdv_channel u_cdv_channel (
      .clk(clk), .rst(rst), .sync_in(sync_in), .hi_cnt(hi_cnt), .lo_cnt(lo_cnt),
      .bypass(bypass), .ign_sync(ign_sync), .force_hi(force_hi),
      .start_hi(start_hi), .phase_ofs(ofs_a), .pwr_dn(pwr_dn), .clk_out(out_a));

   cdv_channel u_cdv_channel_b (
      .clk(clk), .rst(rst), .sync_in(sync_in), .hi_cnt(hi_cnt), .lo_cnt(lo_cnt),
      .bypass(bypass), .ign_sync(ign_sync), .force_hi(force_hi),
      .start_hi(start_hi), .phase_ofs(ofs_b), .pwr_dn(pwr_dn), .clk_out(out_b));

   // Level expected t cycles after the restart edge.
   function automatic logic exp_level(int t, logic st, int hi, int lo, int d);
      int p, l1, l2;
      if (t < d) return st;
      p  = t - d;
      l1 = st ? hi + 1 : lo + 1;
      l2 = st ? lo + 1 : hi + 1;
      return ((p % (l1 + l2)) < l1) ? st : ~st;
   endfunction

   task automatic check(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // Compare both channels with the model for n cycles from the restart edge.
   task automatic run_compare(string req, int n);
      for (int t = 0; t < n; t++) begin
         check(req, out_a, exp_level(t, start_hi, hi_cnt, lo_cnt, ofs_a));
         check(req, out_b, exp_level(t, start_hi, hi_cnt, lo_cnt, ofs_b));
         @(negedge clk);
      end
   endtask

   task automatic sync_pulse();
      @(negedge clk); sync_in = 1'b1;
      @(negedge clk); sync_in = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd2024));
      // R10: reset state
      repeat (3) @(negedge clk);
      check("R10 reset level", out_a, 1'b0);
      rst = 1'b0;
      run_compare("R10 R1 R2 after reset", 8);

      // R1 R2 R6 R7 R4: directed extremes
      hi_cnt = 4'd15; lo_cnt = 4'd0; start_hi = 1'b1; ofs_a = 4'd0; ofs_b = 4'd15;
      sync_pulse();
      run_compare("R2 R7 hi=15 lo=0", 60);
      hi_cnt = 4'd0; lo_cnt = 4'd15; start_hi = 1'b0; ofs_a = 4'd3; ofs_b = 4'd0;
      sync_pulse();
      run_compare("R1 R6 hi=0 lo=15", 60);

      // R1 R2 R6 R7 R4: randomized counts, two offsets, shared sync
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         hi_cnt   = 4'($urandom_range(0, 15));
         lo_cnt   = 4'($urandom_range(0, 15));
         start_hi = 1'($urandom_range(0, 1));
         ofs_a    = 4'($urandom_range(0, 15));
         ofs_b    = 4'($urandom_range(0, 15));
         sync_in  = 1'b1;
         repeat (2) @(negedge clk);
         check("R4 level while sync held", out_a, start_hi);
         check("R4 level while sync held", out_b, start_hi);
         sync_in = 1'b0;
         run_compare("R1 R2 R4 R6 R7 random", 70);
      end

      // R4: sync reasserted mid-waveform realigns
      hi_cnt = 4'd2; lo_cnt = 4'd4; start_hi = 1'b0; ofs_a = 4'd1; ofs_b = 4'd1;
      sync_pulse();
      repeat (5) @(negedge clk);
      sync_pulse();
      run_compare("R4 realign equal offsets", 30);

      // R5: static force levels, sync ignored
      @(negedge clk); ign_sync = 1'b1; force_hi = 1'b1;
      sync_in = 1'b1;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         check("R5 force high", out_a, 1'b1);
         sync_in = 1'(k % 2);
      end
      force_hi = 1'b0; sync_in = 1'b1;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         check("R5 force low", out_a, 1'b0);
         check("R5 force low", out_b, 1'b0);
         sync_in = 1'(k % 2);
      end
      sync_in = 1'b0; ign_sync = 1'b0;

      // R3: bypass follows clk
      bypass = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(posedge clk); #2;
         check("R3 bypass high half", out_a, 1'b1);
         @(negedge clk); #2;
         check("R3 bypass low half", out_a, 1'b0);
      end
      @(negedge clk); bypass = 1'b0;

      // R8 R9: power-down then restart
      hi_cnt = 4'd1; lo_cnt = 4'd3; start_hi = 1'b1; ofs_a = 4'd2; ofs_b = 4'd5;
      sync_pulse();
      repeat (3) @(negedge clk);
      pwr_dn = 1'b1;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         check("R8 power-down low", out_a, 1'b0);
         check("R8 power-down low", out_b, 1'b0);
      end
      pwr_dn = 1'b0;
      @(negedge clk);
      run_compare("R9 restart after power-down", 40);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule